// File: doc/BRIEF.md
# OLED Panel Power and Initialization Sequencer

This block brings an OLED panel and its driver chip up and down in a fixed, panel-safe order. It switches the logic rail and the panel high-voltage rail, pulses the driver's active-low reset, and pushes command and data bytes to a serial writer downstream. Power-up raises the logic rail, holds reset low, sends display-off, writes a short table of setup commands, zero-fills the display memory, raises the high-voltage rail, lets it settle, and finally sends display-on. Power-down reverses this: display-off, high-voltage rail off, a discharge wait, then logic rail off.

All waits count milliseconds. A prescaler turns the system clock into a millisecond tick. The number of clocks per millisecond is a parameter, so a simulation can run the whole sequence in a few thousand cycles.

Bytes leave on a valid/ready stream. The sequencer holds `tx_valid` with a stable byte and data/command flag until `tx_ready` is high on a clock edge. That edge is the transfer. After a transfer, the sequencer presents nothing more until the writer returns a one-cycle `tx_done`. A `tx_done` that arrives while no transfer is outstanding is ignored. The writer may hold `tx_ready` low for any number of cycles.

Top module: `oled_pwr_seq`

## Requirements
- R1: While reset is applied and right after it is released, the block drives these values: `vdd_en`=0, `vhv_en`=0, `drv_rst_n`=0, `ready`=0, `tx_valid`=0 and `state`=0.
- R2: A power-on request in the off state raises `vdd_en` first, with `drv_rst_n` still low. `drv_rst_n` stays low with `vdd_en` high for exactly RST_MS×CLKS_PER_MS cycles. It then rises before any byte is transferred.
- R3: Power-up transfers bytes in this order:
  - 0xAE with `tx_dc`=0;
  - INIT_LEN table bytes with `tx_dc`=0, where byte k has the value 0xC0+k;
  - CLEAR_BYTES bytes of 0x00 with `tx_dc`=1;
  - 0xAF with `tx_dc`=0.
- R4: `vhv_en` is low for every power-up byte except the final 0xAF. It rises when the last clear byte's `tx_done` is seen. It then holds high for exactly HV_SETTLE_MS×CLKS_PER_MS cycles before 0xAF is offered.
- R5: `vhv_en` is never high unless `vdd_en` and `drv_rst_n` are both high.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte` and `tx_dc` hold their values. After a transfer, `tx_valid` stays low until `tx_done` is seen.
- R7: A power-off request in the on state transfers 0xAE with `tx_dc`=0 while `vhv_en` is still high. It then drops `vhv_en` and holds `vdd_en` high for exactly DISCHARGE_MS×CLKS_PER_MS cycles. After that it returns to the R1 output values.
- R8: A power-off request made at any point during power-up is remembered. The block still completes power-up, shows `ready` for at least one cycle, and then runs power-down without a further request.
- R9: A power-on request outside the off state has no effect. A power-off request in the off state has no effect.
- R10: The `state` port reports the sequencer phase with these codes:

  | Code | Phase |
  |------|-------|
  | 0 | off |
  | 1 | reset hold |
  | 2 | display-off |
  | 3 | table |
  | 4 | clear |
  | 5 | high-voltage settle |
  | 6 | display-on |
  | 7 | on |
  | 8 | power-down display-off |
  | 9 | discharge |

- R11: `ready` is high exactly when `state` is 7. In that state `vdd_en`, `vhv_en` and `drv_rst_n` are all high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Request to start power-up |
| pwr_off_req | input | 1 | Request to start power-down |
| tx_ready | input | 1 | Serial writer accepts the offered byte |
| tx_done | input | 1 | One-cycle pulse: the serial writer has finished the last byte |
| tx_valid | output | 1 | A byte is offered to the serial writer |
| tx_dc | output | 1 | 1 = display data, 0 = command |
| tx_byte | output | 8 | Offered byte |
| vdd_en | output | 1 | Logic rail enable |
| vhv_en | output | 1 | Panel high-voltage rail enable |
| drv_rst_n | output | 1 | Active-low reset to the driver chip |
| ready | output | 1 | Panel is on and usable |
| state | output | 4 | Sequencer phase code (R10) |

## Verification
The assertions assume that the serial writer returns `tx_done` only after a transfer it has accepted. They also assume that requests are single-cycle pulses. The bench's writer model follows both rules. It pulses `tx_done` a fixed, configurable number of cycles after each accepted byte. It stalls `tx_ready` on a periodic pattern. The bench sweeps four combinations of stall period and completion latency, so that the stable-hold rule is exercised both with and without back-pressure. It drives every request as a one-cycle pulse on the falling edge.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF       = 4'd0,
    ST_RST_HOLD  = 4'd1,
    ST_DOFF      = 4'd2,
    ST_INIT      = 4'd3,
    ST_CLEAR     = 4'd4,
    ST_HV_SETTLE = 4'd5,
    ST_DON       = 4'd6,
    ST_ON        = 4'd7,
    ST_PD_DOFF   = 4'd8,
    ST_PD_DISCH  = 4'd9
  } seq_state_t;

  localparam logic [7:0] CMD_PANEL_OFF = 8'hAE;
  localparam logic [7:0] CMD_PANEL_ON  = 8'hAF;
  localparam logic [7:0] TABLE_BASE    = 8'hC0;

  function automatic logic state_sends(seq_state_t s);
    return (s == ST_DOFF) || (s == ST_INIT) || (s == ST_CLEAR) ||
           (s == ST_DON) || (s == ST_PD_DOFF);
  endfunction

  function automatic logic state_in_powerup(seq_state_t s);
    return (s >= ST_RST_HOLD) && (s <= ST_DON);
  endfunction

endpackage

// File: rtl/oled_ms_timer.sv
module oled_ms_timer #(
  parameter int CLKS_PER_MS = 100000,
  parameter int MS_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms_len,
  output logic            busy,
  output logic            expire
);
  localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(CLKS_PER_MS - 1);

  logic [PW-1:0]   pre_q;
  logic [MS_W-1:0] ms_q;

  assign expire = busy && (pre_q == '0) && (ms_q == MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pre_q <= '0;
      ms_q  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      pre_q <= PRE_TOP;
      ms_q  <= ms_len;
    end else if (busy) begin
      if (pre_q == '0) begin
        pre_q <= PRE_TOP;
        ms_q  <= ms_q - MS_W'(1);
        if (ms_q == MS_W'(1)) busy <= 1'b0;
      end else begin
        pre_q <= pre_q - PW'(1);
      end
    end
  end

  // R2, R4, R7: the remaining millisecond count never grows while a wait runs
  p_ms_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> ms_q <= $past(ms_q));

  // R4: the prescaler stays inside one millisecond
  p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pre_q <= PRE_TOP);

endmodule

// File: rtl/oled_init_table.sv
module oled_init_table #(
  parameter int INIT_LEN = 6,
  parameter int IW       = 3
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    byte_o
);
  import oled_seq_pkg::*;

  logic [7:0] entry [INIT_LEN];

  for (genvar g = 0; g < INIT_LEN; g++) begin : g_entry
    assign entry[g] = TABLE_BASE + 8'(g);
  end

  always_comb begin
    byte_o = 8'h00;
    for (int k = 0; k < INIT_LEN; k++) begin
      if (idx == IW'(k)) byte_o = entry[k];
    end
  end

endmodule

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq #(
  parameter int CLKS_PER_MS  = 100000,
  parameter int RST_MS       = 10,
  parameter int HV_SETTLE_MS = 100,
  parameter int DISCHARGE_MS = 100,
  parameter int INIT_LEN     = 6,
  parameter int CLEAR_BYTES  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       pwr_off_req,
  input  logic       tx_ready,
  input  logic       tx_done,
  output logic       tx_valid,
  output logic       tx_dc,
  output logic [7:0] tx_byte,
  output logic       vdd_en,
  output logic       vhv_en,
  output logic       drv_rst_n,
  output logic       ready,
  output logic [3:0] state
);
  import oled_seq_pkg::*;

  localparam int MS_MAX0 = (RST_MS > HV_SETTLE_MS) ? RST_MS : HV_SETTLE_MS;
  localparam int MS_MAX  = (MS_MAX0 > DISCHARGE_MS) ? MS_MAX0 : DISCHARGE_MS;
  localparam int MS_W    = $clog2(MS_MAX + 1);
  localparam int CNT_MAX = (CLEAR_BYTES > INIT_LEN) ? CLEAR_BYTES : INIT_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IW      = (INIT_LEN > 1) ? $clog2(INIT_LEN) : 1;

  seq_state_t       state_q, state_d;
  logic             wait_q;
  logic [CNT_W-1:0] idx_q;
  logic             off_pend_q;

  logic             tmr_start, tmr_busy, tmr_expire;
  logic [MS_W-1:0]  tmr_len;
  logic [7:0]       table_byte;
  logic             accept, byte_done, last_byte;

  oled_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .ms_len (tmr_len),
    .busy   (tmr_busy),
    .expire (tmr_expire)
  );

  oled_init_table #(.INIT_LEN(INIT_LEN), .IW(IW)) u_table (
    .idx    (idx_q[IW-1:0]),
    .byte_o (table_byte)
  );

  assign tx_valid  = state_sends(state_q) && !wait_q;
  assign accept    = tx_valid && tx_ready;
  assign byte_done = wait_q && tx_done;

  always_comb begin
    tx_dc   = 1'b0;
    tx_byte = 8'h00;
    unique case (state_q)
      ST_DOFF, ST_PD_DOFF: tx_byte = CMD_PANEL_OFF;
      ST_DON:              tx_byte = CMD_PANEL_ON;
      ST_INIT:             tx_byte = table_byte;
      ST_CLEAR:            tx_dc   = 1'b1;
      default:             tx_byte = 8'h00;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_INIT:  last_byte = (idx_q == CNT_W'(INIT_LEN - 1));
      ST_CLEAR: last_byte = (idx_q == CNT_W'(CLEAR_BYTES - 1));
      default:  last_byte = 1'b1;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    tmr_len   = MS_W'(RST_MS);
    unique case (state_q)
      ST_OFF: if (pwr_on_req) begin
        state_d   = ST_RST_HOLD;
        tmr_start = 1'b1;
        tmr_len   = MS_W'(RST_MS);
      end
      ST_RST_HOLD:  if (tmr_expire) state_d = ST_DOFF;
      ST_DOFF:      if (byte_done) state_d = ST_INIT;
      ST_INIT:      if (byte_done && last_byte) state_d = ST_CLEAR;
      ST_CLEAR: if (byte_done && last_byte) begin
        state_d   = ST_HV_SETTLE;
        tmr_start = 1'b1;
        tmr_len   = MS_W'(HV_SETTLE_MS);
      end
      ST_HV_SETTLE: if (tmr_expire) state_d = ST_DON;
      ST_DON:       if (byte_done) state_d = ST_ON;
      ST_ON:        if (pwr_off_req || off_pend_q) state_d = ST_PD_DOFF;
      ST_PD_DOFF: if (byte_done) begin
        state_d   = ST_PD_DISCH;
        tmr_start = 1'b1;
        tmr_len   = MS_W'(DISCHARGE_MS);
      end
      ST_PD_DISCH:  if (tmr_expire) state_d = ST_OFF;
      default:      state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OFF;
      wait_q     <= 1'b0;
      idx_q      <= '0;
      off_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept)         wait_q <= 1'b1;
      else if (byte_done) wait_q <= 1'b0;
      if (state_d != state_q)             idx_q <= '0;
      else if (byte_done && !last_byte)   idx_q <= idx_q + CNT_W'(1);
      if (state_d == ST_PD_DOFF)
        off_pend_q <= 1'b0;
      else if (pwr_off_req && state_in_powerup(state_q))
        off_pend_q <= 1'b1;
    end
  end

  assign vdd_en    = (state_q != ST_OFF);
  assign drv_rst_n = (state_q != ST_OFF) && (state_q != ST_RST_HOLD);
  assign vhv_en    = (state_q == ST_HV_SETTLE) || (state_q == ST_DON) ||
                     (state_q == ST_ON) || (state_q == ST_PD_DOFF);
  assign ready     = (state_q == ST_ON);
  assign state     = state_q;

  // R5: high voltage only with logic rail up and driver out of reset
  p_hv_needs_logic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vhv_en |-> vdd_en && drv_rst_n);

  // R6: an offered byte is held until taken
  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_dc));

  // R6: nothing offered in the cycle after a transfer
  p_one_per_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid);

  // R2: reset released only after the logic rail was up
  p_rst_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_rst_n) |-> $past(vdd_en));

  // R11: ready implies all rails up
  p_ready_rails_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> vdd_en && vhv_en && drv_rst_n);

  // R10: only defined phase codes
  p_state_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 4'd9);

  // R4: every timed phase is backed by a running timer
  p_timer_in_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RST_HOLD || state_q == ST_HV_SETTLE || state_q == ST_PD_DISCH)
      |-> tmr_busy);

endmodule

// File: tb/oled_pwr_seq_tb.sv
module oled_pwr_seq_tb;
  localparam int C    = 3;
  localparam int RMS  = 10;
  localparam int HMS  = 100;
  localparam int DMS  = 100;
  localparam int NI   = 6;
  localparam int NC   = 512;
  localparam int NUP  = 1 + NI + NC + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on_req = 1'b0, pwr_off_req = 1'b0;
  logic       tx_ready = 1'b0, tx_done = 1'b0;
  logic       tx_valid, tx_dc, vdd_en, vhv_en, drv_rst_n, ready;
  logic [7:0] tx_byte;
  logic [3:0] state;

  int checks = 0, errors = 0;
  int rp = 1, lat = 0, rctr = 0, dcnt = 0;
  int nlog = 0;
  logic [7:0] log_b  [0:1199];
  logic       log_dc [0:1199];
  logic       log_hv [0:1199];
  int cnt_rst = 0, cnt_hv = 0, cnt_dis = 0, bad_safe = 0, bad_ready = 0, bad_order = 0;
  logic saw_ready = 1'b0;

  always #4 clk = ~clk;

  oled_pwr_seq #(.CLKS_PER_MS(C), .RST_MS(RMS), .HV_SETTLE_MS(HMS),
                 .DISCHARGE_MS(DMS), .INIT_LEN(NI), .CLEAR_BYTES(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_valid(tx_valid), .tx_dc(tx_dc),
    .tx_byte(tx_byte), .vdd_en(vdd_en), .vhv_en(vhv_en), .drv_rst_n(drv_rst_n),
    .ready(ready), .state(state));

  // serial writer model and monitors, on the falling edge
  always @(negedge clk) begin
    tx_done = 1'b0;
    if (dcnt > 0) begin
      dcnt = dcnt - 1;
      if (dcnt == 0) tx_done = 1'b1;
    end
    rctr = rctr + 1;
    tx_ready = ((rctr % rp) == 0);
    if (rst_n && tx_valid && tx_ready) begin
      if (nlog < 1200) begin
        log_b[nlog] = tx_byte; log_dc[nlog] = tx_dc; log_hv[nlog] = vhv_en;
      end
      nlog = nlog + 1;
      dcnt = lat + 1;
    end
    if (rst_n) begin
      if (state == 4'd1 && vdd_en && !drv_rst_n) cnt_rst++;
      if (state == 4'd5 && vhv_en) cnt_hv++;
      if (state == 4'd9 && !vhv_en && vdd_en) cnt_dis++;
      if (vhv_en && !(vdd_en && drv_rst_n)) bad_safe++;
      if (ready != (state == 4'd7)) bad_ready++;
      if (drv_rst_n && !vdd_en) bad_order++;
      if (ready) saw_ready = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_on();
    @(negedge clk); pwr_on_req = 1'b1; @(negedge clk); pwr_on_req = 1'b0;
  endtask

  task automatic pulse_off();
    @(negedge clk); pwr_off_req = 1'b1; @(negedge clk); pwr_off_req = 1'b0;
  endtask

  task automatic wait_state(input logic [3:0] s);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (state == s) return;
    end
  endtask

  task automatic clear_mon();
    nlog = 0; cnt_rst = 0; cnt_hv = 0; cnt_dis = 0; saw_ready = 1'b0;
  endtask

  task automatic check_powerup(input string cfg);
    int bad_i, bad_c;
    chk(nlog == NUP, {"R3 byte count ", cfg}, nlog, NUP);
    chk(log_b[0] == 8'hAE && !log_dc[0], {"R3 first display-off ", cfg}, log_b[0], 8'hAE);
    bad_i = 0;
    for (int k = 0; k < NI; k++)
      if (log_b[1+k] != 8'(8'hC0 + k) || log_dc[1+k]) bad_i++;
    chk(bad_i == 0, {"R3 table bytes ", cfg}, bad_i, 0);
    bad_c = 0;
    for (int k = 0; k < NC; k++)
      if (log_b[1+NI+k] != 8'h00 || !log_dc[1+NI+k]) bad_c++;
    chk(bad_c == 0, {"R3 clear bytes ", cfg}, bad_c, 0);
    chk(log_b[NUP-1] == 8'hAF && !log_dc[NUP-1], {"R3 display-on ", cfg}, log_b[NUP-1], 8'hAF);
    bad_i = 0;
    for (int k = 0; k < NUP - 1; k++) if (log_hv[k]) bad_i++;
    chk(bad_i == 0 && log_hv[NUP-1], {"R4 hv only for display-on ", cfg}, bad_i, 0);
    chk(cnt_rst == RMS * C, {"R2 reset hold cycles ", cfg}, cnt_rst, RMS * C);
    chk(cnt_hv == HMS * C, {"R4 hv settle cycles ", cfg}, cnt_hv, HMS * C);
    chk(ready && vdd_en && vhv_en && drv_rst_n, {"R11 on state rails ", cfg}, {ready, vdd_en, vhv_en, drv_rst_n}, 4'hF);
  endtask

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    chk({vdd_en, vhv_en, drv_rst_n, ready, tx_valid} == 5'b0 && state == 4'd0,
        "R1 during reset", {vdd_en, vhv_en, drv_rst_n, ready, tx_valid, state}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({vdd_en, vhv_en, drv_rst_n, ready, tx_valid} == 5'b0 && state == 4'd0,
        "R1 after reset", {vdd_en, vhv_en, drv_rst_n, ready, tx_valid, state}, 0);

    // R9: power-off in off state ignored
    pulse_off();
    repeat (20) @(negedge clk);
    chk(state == 4'd0 && !vdd_en, "R9 off request in off", state, 0);

    // sweep of back-pressure and completion latency
    for (int cfg = 0; cfg < 4; cfg++) begin
      rp  = (cfg % 2) + 1 + (cfg / 2);
      lat = cfg;
      clear_mon();
      pulse_on();
      @(negedge clk);
      chk(vdd_en && !drv_rst_n && state == 4'd1, $sformatf("R2 rail first cfg%0d", cfg), state, 1);
      wait_state(4'd7);
      check_powerup($sformatf("cfg%0d", cfg));
      // R9: on request while on is ignored
      pulse_on();
      repeat (10) @(negedge clk);
      chk(state == 4'd7 && ready, $sformatf("R9 on request while on cfg%0d", cfg), state, 7);
      // R7: power-down
      pulse_off();
      wait_state(4'd0);
      chk(nlog == NUP + 1 && log_b[NUP] == 8'hAE && !log_dc[NUP] && log_hv[NUP],
          $sformatf("R7 power-down display-off cfg%0d", cfg), log_b[NUP], 8'hAE);
      chk(cnt_dis == DMS * C, $sformatf("R7 discharge cycles cfg%0d", cfg), cnt_dis, DMS * C);
      chk({vdd_en, vhv_en, drv_rst_n, ready} == 4'b0, $sformatf("R7 back off cfg%0d", cfg),
          {vdd_en, vhv_en, drv_rst_n, ready}, 0);
    end

    // R8: off request during power-up is latched
    rp = 2; lat = 1;
    clear_mon();
    pulse_on();
    wait_state(4'd4);
    chk(state == 4'd4, "R10 clear phase code", state, 4);
    pulse_off();
    wait_state(4'd0);
    chk(saw_ready, "R8 ready shown before latched power-down", saw_ready, 1);
    chk(state == 4'd0 && nlog == NUP + 1 && log_b[NUP] == 8'hAE, "R8 latched power-down ran",
        nlog, NUP + 1);

    chk(bad_safe == 0, "R5 hv without logic rail", bad_safe, 0);
    chk(bad_ready == 0, "R11 ready vs state", bad_ready, 0);
    chk(bad_order == 0, "R2 reset released without rail", bad_order, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule